// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block turns single-byte requests from a synchronous front end into read and write cycles on an asynchronous, SRAM-style memory bus. The memory bus carries a 17-bit address, an 8-bit data path, and three active-low strobes: chip select, write strobe and output enable. A requester offers a request with a valid signal and holds it until the controller raises ready. A write needs no response. A read returns its byte together with a one-clock done pulse.

Every bus timing minimum is given as a nanosecond parameter. The controller converts each one into whole clocks by rounding up against a clock-period parameter. With the defaults (8 ns clock) this gives:

- a read window of 6 clocks;
- a write made of 1 setup clock, 3 write-strobe clocks and 2 recovery clocks;
- at least 1 deselected clock between cycles;
- at least 2 clocks between output enable rising and the controller driving data.

Write cycles are ended by the write strobe. Output enable is never low while the write strobe is low. The data path is split into an output byte, a drive-enable and an input byte, so a pad ring outside this block can form the bidirectional pins.

Top module: `sram_bus_ctl`

## Requirements
- R1: During and right after reset, chip select, write strobe and output enable are all high (1), the data drive-enable is 0, done is 0, and ready is 1.
- R2: An accepted read holds chip select and output enable low, with the write strobe high, for exactly READ_CLKS consecutive clocks (6 at defaults), starting the clock after acceptance. The address is stable throughout.
- R3: The read byte is sampled at the clock edge that ends the last read-window clock. In the very next clock, done is 1 for exactly one clock and the read-data output shows that byte.
- R4: An accepted write runs three phases, starting the clock after acceptance, with address and write data held on the bus throughout:
  - SETUP_CLKS clocks with chip select low and write strobe high;
  - PULSE_CLKS clocks with chip select and write strobe both low;
  - RECOV_CLKS clocks with chip select and write strobe both high.
  At defaults these are 1, 3 and 2 clocks. The write strobe is never low while chip select is high.
- R5: Output enable stays high on every clock in which the write strobe is low, and on every clock of a write.
- R6: The data drive-enable is 1 exactly during the setup, strobe and recovery clocks of a write, and is never 1 while output enable is low.
- R7: Between any two cycles, chip select stays high for at least HIGH_CLKS clocks (1 at defaults). Two back-to-back reads therefore need only that gap.
- R8: A write that follows a read is not accepted until output enable has been high for TURN_CLKS clocks (2 at defaults) before the data drive-enable rises.
- R9: Ready is 0 during every clock of a cycle. A request that is offered while the controller is busy is held off, not dropped, and is accepted in a later clock.
- R10: A written byte read back from the same address returns that byte, including at the lowest and highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-clock pulse when read data is valid |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_addr | output | 17 | Memory bus address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data pins |
| mem_dq_oe | output | 1 | 1 = controller drives the data pins |
| mem_dq_in | input | 8 | Byte sampled from the data pins |

## Verification
The assertions check, on every clock, the properties that hold whatever the traffic:
- output enable and the write strobe are never low together;
- data is never driven against an enabled memory output;
- the write strobe is never low while chip select is high;
- the address is stable while chip select is low;
- each write-strobe pulse lasts its full length;
- the deselect gap and the read-to-write turnaround are respected;
- done is a single-clock pulse;
- ready stays low while busy.

Only the bench scenarios can show the rest:
- that each phase has exactly the right length;
- that the byte is sampled on the last read clock and not earlier (the bench memory drives a wrong value until then);
- that held-off requests are eventually accepted in order;
- that bytes written at the address extremes come back intact.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_READ    = 3'd1,
    PH_WSETUP  = 3'd2,
    PH_WPULSE  = 3'd3,
    PH_WRECOV  = 3'd4
  } phase_t;

  // Strobe levels as they appear on the bus (active-low selects).
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } strobe_t;

  // Whole clocks needed to cover a nanosecond minimum.
  function automatic int unsigned clocks_for(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Difference clamped at zero.
  function automatic int unsigned sub0(input int unsigned a, input int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

  function automatic int unsigned atleast1(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Bits needed to hold the value v.
  function automatic int width_for(input int unsigned v);
    int w;
    w = $clog2(v + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Bus strobe levels for each phase.
  function automatic strobe_t strobes_of(input phase_t ph);
    strobe_t s;
    s = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    case (ph)
      PH_READ:   begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
      PH_WSETUP: begin s.ce_n = 1'b0; s.drive = 1'b1; end
      PH_WPULSE: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.drive = 1'b1; end
      PH_WRECOV: begin s.drive = 1'b1; end
      default:   ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned SETUP_CLKS = 1,
  parameter int unsigned PULSE_CLKS = 3,
  parameter int unsigned RECOV_CLKS = 2,
  parameter int unsigned READ_CLKS  = 6,
  parameter int unsigned HIGH_CLKS  = 1,
  parameter int unsigned TURN_CLKS  = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  output logic    req_ready,
  output logic    load,
  output logic    capture,
  output strobe_t strobe_d
);

  localparam int unsigned CMAX = max2(max2(READ_CLKS, SETUP_CLKS), max2(PULSE_CLKS, RECOV_CLKS));
  localparam int          CW   = width_for(CMAX);
  localparam int unsigned GMAX = max2(HIGH_CLKS, TURN_CLKS);
  localparam int          GW   = width_for(GMAX);

  phase_t          ph_q, ph_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [GW-1:0]   gap_q;
  logic            last_rd_q;
  logic            cnt_end;
  logic            gap_ok_hi;
  logic            gap_ok_turn;

  assign cnt_end     = (cnt_q == '0);
  assign gap_ok_hi   = (gap_q >= GW'(HIGH_CLKS - 1));
  assign gap_ok_turn = (gap_q >= GW'(TURN_CLKS - 1));
  assign req_ready   = (ph_q == PH_IDLE) && gap_ok_hi &&
                       (!(last_rd_q && req_write) || gap_ok_turn);
  assign load        = req_valid && req_ready;
  assign capture     = (ph_q == PH_READ) && cnt_end;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      PH_IDLE: begin
        if (load) begin
          if (req_write) begin
            ph_d  = PH_WSETUP;
            cnt_d = CW'(SETUP_CLKS - 1);
          end else begin
            ph_d  = PH_READ;
            cnt_d = CW'(READ_CLKS - 1);
          end
        end
      end
      PH_READ: begin
        if (cnt_end) ph_d = PH_IDLE;
        else         cnt_d = cnt_q - 1'b1;
      end
      PH_WSETUP: begin
        if (cnt_end) begin
          ph_d  = PH_WPULSE;
          cnt_d = CW'(PULSE_CLKS - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_WPULSE: begin
        if (cnt_end) begin
          ph_d  = PH_WRECOV;
          cnt_d = CW'(RECOV_CLKS - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_WRECOV: begin
        if (cnt_end) ph_d = PH_IDLE;
        else         cnt_d = cnt_q - 1'b1;
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  assign strobe_d = strobes_of(ph_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      gap_q     <= '1;
      last_rd_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (ph_q != PH_IDLE)  gap_q <= '0;
      else if (gap_q != '1) gap_q <= gap_q + 1'b1;
      if (ph_q == PH_READ)        last_rd_q <= 1'b1;
      else if (ph_q == PH_WSETUP) last_rd_q <= 1'b0;
    end
  end

  // R9: no request is taken while a cycle runs
  p_busy_holds_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |-> !req_ready);

  // R9: an accepted request always starts a cycle
  p_accept_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ph_q != PH_IDLE));

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe_d,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] data_d,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              drive,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  // Strobes come straight from flops so the asynchronous bus sees no glitches.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_n   <= 1'b1;
      we_n   <= 1'b1;
      oe_n   <= 1'b1;
      drive  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ce_n  <= strobe_d.ce_n;
      we_n  <= strobe_d.we_n;
      oe_n  <= strobe_d.oe_n;
      drive <= strobe_d.drive;
      if (load) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  // R5: output enable is never active during the write strobe
  p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R6: no drive against an enabled memory output
  p_drive_no_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> oe_n);

  // R4: the write strobe is low only inside a chip select
  p_we_within_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= capture;
      if (capture) rdata <= dq_in;
    end
  end

  // R3: done lasts one clock
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: returned byte holds between reads
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(rdata));

endmodule

// File: rtl/sram_bus_ctl.sv
module sram_bus_ctl
  import sram_ctl_pkg::*;
#(
  parameter int          ADDR_W      = 17,
  parameter int          DATA_W      = 8,
  parameter int unsigned CLK_NS      = 8,
  parameter int unsigned T_CYCLE_NS  = 45,
  parameter int unsigned T_ACC_NS    = 45,
  parameter int unsigned T_OEACC_NS  = 20,
  parameter int unsigned T_ASU_NS    = 0,
  parameter int unsigned T_AVEND_NS  = 25,
  parameter int unsigned T_WPW_NS    = 20,
  parameter int unsigned T_DSU_NS    = 15,
  parameter int unsigned T_WREC_NS   = 12,
  parameter int unsigned T_HIGH_NS   = 2,
  parameter int unsigned T_REL_NS    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned CYC_CLKS   = clocks_for(T_CYCLE_NS, CLK_NS);
  localparam int unsigned SETUP_CLKS = atleast1(clocks_for(T_ASU_NS, CLK_NS));
  localparam int unsigned PULSE_CLKS = atleast1(max2(
      max2(clocks_for(T_WPW_NS, CLK_NS), clocks_for(T_DSU_NS, CLK_NS)),
      sub0(clocks_for(T_AVEND_NS, CLK_NS), SETUP_CLKS)));
  localparam int unsigned RECOV_CLKS = atleast1(max2(clocks_for(T_WREC_NS, CLK_NS),
      sub0(CYC_CLKS, SETUP_CLKS + PULSE_CLKS)));
  localparam int unsigned READ_CLKS  = atleast1(max2(CYC_CLKS,
      max2(clocks_for(T_ACC_NS, CLK_NS), clocks_for(T_OEACC_NS, CLK_NS))));
  localparam int unsigned HIGH_CLKS  = atleast1(clocks_for(T_HIGH_NS, CLK_NS));
  localparam int unsigned TURN_CLKS  = atleast1(clocks_for(T_REL_NS, CLK_NS));
  localparam int          RW         = width_for(max2(HIGH_CLKS, TURN_CLKS));
  localparam int          PW         = width_for(PULSE_CLKS);

  strobe_t strobe_d;
  logic    load;
  logic    capture;

  sram_ctl_seq #(
    .SETUP_CLKS (SETUP_CLKS),
    .PULSE_CLKS (PULSE_CLKS),
    .RECOV_CLKS (RECOV_CLKS),
    .READ_CLKS  (READ_CLKS),
    .HIGH_CLKS  (HIGH_CLKS),
    .TURN_CLKS  (TURN_CLKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .load      (load),
    .capture   (capture),
    .strobe_d  (strobe_d)
  );

  sram_ctl_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_d (strobe_d),
    .load     (load),
    .addr_d   (req_addr),
    .data_d   (req_wdata),
    .ce_n     (mem_ce_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .drive    (mem_dq_oe),
    .addr_q   (mem_addr),
    .data_q   (mem_dq_out)
  );

  sram_ctl_rdcap #(
    .DATA_W (DATA_W)
  ) u_rdcap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .dq_in   (mem_dq_in),
    .done    (rsp_done),
    .rdata   (rsp_rdata)
  );

  // Run-length counters of the bus pins, kept for the timing checks below.
  logic [RW-1:0] ce_hi_run;
  logic [RW-1:0] oe_hi_run;
  logic [PW-1:0] we_lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_hi_run <= '1;
      oe_hi_run <= '1;
      we_lo_run <= '0;
    end else begin
      if (!mem_ce_n)             ce_hi_run <= '0;
      else if (ce_hi_run != '1)  ce_hi_run <= ce_hi_run + 1'b1;
      if (!mem_oe_n)             oe_hi_run <= '0;
      else if (oe_hi_run != '1)  oe_hi_run <= oe_hi_run + 1'b1;
      if (mem_we_n)              we_lo_run <= '0;
      else if (we_lo_run != '1)  we_lo_run <= we_lo_run + 1'b1;
    end
  end

  // R7: deselect gap before each new chip select
  p_ce_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (ce_hi_run >= RW'(HIGH_CLKS)));

  // R8: memory output released before the controller drives
  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_run >= RW'(TURN_CLKS)));

  // R4: full write strobe width
  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_run >= PW'(PULSE_CLKS)));

  // R2: address steady while selected
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_bus_ctl_test.sv
module sram_bus_ctl_test;

  localparam int CLK_NS = 8;
  localparam int NOPS   = 11;

  function automatic int up(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected counts derived from the nanosecond minimums.
  localparam int SETC = 1;
  localparam int PULC = mx(mx(up(20), up(15)), up(25) - SETC);
  localparam int RECC = mx(up(12), up(45) - SETC - PULC);
  localparam int RDC  = mx(up(45), up(20));
  localparam int HIC  = mx(1, up(2));
  localparam int TRC  = mx(1, up(15));

  typedef struct {
    bit ce_n; bit we_n; bit oe_n; bit drive;
    int addr; int data; bit is_rd; bit last;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'h5A;

  always #4 clk = ~clk;

  sram_bus_ctl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int n_vec = 0;
  int n_bad = 0;

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  logic [7:0] bus_mem [int];
  logic [7:0] ref_mem [int];

  function automatic logic [7:0] bus_rd(input int a);
    return bus_mem.exists(a) ? bus_mem[a] : 8'h6E;
  endfunction
  function automatic logic [7:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h6E;
  endfunction

  bit op_wr [NOPS];
  int op_addr [NOPS];
  int op_data [NOPS];
  int op_dly [NOPS];

  exp_t q[$];

  initial begin
    exp_t e;
    exp_t t;
    bit   busy;
    bit   done_pend;
    int   exp_rd;
    bit   last_rd;
    int   idle_run;
    int   rd_age;
    int   op_i;
    int   wait_cnt;
    bit   accepted;
    int   cyc;
    int   tail;
    bit   exp_ready;
    string ptag;

    // write/read plan: address extremes, back-to-back orders, held-off requests
    op_wr[0]=1; op_addr[0]=17'h00010; op_data[0]=8'hA5; op_dly[0]=0;
    op_wr[1]=0; op_addr[1]=17'h00010; op_data[1]=0;     op_dly[1]=0;
    op_wr[2]=1; op_addr[2]=17'h1FFFF; op_data[2]=8'h3C; op_dly[2]=0;
    op_wr[3]=0; op_addr[3]=17'h1FFFF; op_data[3]=0;     op_dly[3]=0;
    op_wr[4]=0; op_addr[4]=17'h00010; op_data[4]=0;     op_dly[4]=0;
    op_wr[5]=1; op_addr[5]=17'h00000; op_data[5]=8'hFF; op_dly[5]=3;
    op_wr[6]=1; op_addr[6]=17'h00001; op_data[6]=8'h00; op_dly[6]=0;
    op_wr[7]=0; op_addr[7]=17'h00000; op_data[7]=0;     op_dly[7]=0;
    op_wr[8]=0; op_addr[8]=17'h00001; op_data[8]=0;     op_dly[8]=2;
    op_wr[9]=0; op_addr[9]=17'h12345; op_data[9]=0;     op_dly[9]=0;
    op_wr[10]=1; op_addr[10]=17'h12345; op_data[10]=8'h96; op_dly[10]=5;

    // R1: state held in reset
    repeat (3) @(negedge clk);
    check("R1", "ce_n", mem_ce_n, 1);
    check("R1", "we_n", mem_we_n, 1);
    check("R1", "oe_n", mem_oe_n, 1);
    check("R1", "dq_oe", mem_dq_oe, 0);
    check("R1", "done", rsp_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", req_ready, 1);
    check("R1", "ce_n after reset", mem_ce_n, 1);

    done_pend = 0; exp_rd = 0; last_rd = 0; idle_run = 100; rd_age = 0;
    op_i = 0; wait_cnt = 0; accepted = 0; cyc = 0; tail = 0;

    while (tail < 6) begin
      if (q.size() > 0) begin e = q.pop_front(); busy = 1; end
      else begin
        busy = 0;
        e = '{ce_n:1, we_n:1, oe_n:1, drive:0, addr:0, data:0, is_rd:0, last:0};
      end
      ptag = !busy ? "R7" : (e.is_rd ? "R2" : "R4");
      check(ptag, "ce_n", mem_ce_n, e.ce_n);
      check(ptag, "we_n", mem_we_n, e.we_n);
      check("R5", "oe_n", mem_oe_n, e.oe_n);
      check("R6", "dq_oe", mem_dq_oe, e.drive);
      if (busy) check(ptag, "addr", mem_addr, e.addr);
      if (busy && e.drive) check("R4", "dq_out", mem_dq_out, e.data);
      check("R3", "done", rsp_done, done_pend);
      if (done_pend) check("R10", "rdata", rsp_rdata, exp_rd);
      done_pend = busy && e.last;
      if (done_pend) exp_rd = e.data;
      if (busy) last_rd = e.is_rd;

      // behavioural memory on the bus
      if (!mem_ce_n && !mem_we_n) bus_mem[int'(mem_addr)] = mem_dq_out;
      if (!mem_ce_n && !mem_oe_n) rd_age++; else rd_age = 0;
      mem_dq_in = (rd_age >= RDC) ? bus_rd(int'(mem_addr)) : 8'h5A;

      // requester
      if (accepted) begin
        req_valid = 0; op_i++; wait_cnt = 0; accepted = 0;
      end
      if (op_i < NOPS && !req_valid) begin
        if (wait_cnt >= op_dly[op_i]) begin
          req_valid = 1;
          req_write = op_wr[op_i];
          req_addr  = 17'(op_addr[op_i]);
          req_wdata = 8'(op_data[op_i]);
        end else wait_cnt++;
      end
      #1;
      exp_ready = !busy && (idle_run >= HIC - 1) &&
                  (!(last_rd && req_write) || idle_run >= TRC - 1);
      ptag = (!busy && !exp_ready) ? "R8" : "R9";
      check(ptag, "ready", req_ready, exp_ready);
      if (req_valid && exp_ready) begin
        accepted = 1;
        if (req_write) begin
          ref_mem[int'(req_addr)] = req_wdata;
          t = '{ce_n:0, we_n:1, oe_n:1, drive:1, addr:int'(req_addr), data:int'(req_wdata), is_rd:0, last:0};
          for (int k = 0; k < SETC; k++) q.push_back(t);
          t.we_n = 0;
          for (int k = 0; k < PULC; k++) q.push_back(t);
          t.we_n = 1; t.ce_n = 1;
          for (int k = 0; k < RECC; k++) q.push_back(t);
        end else begin
          t = '{ce_n:0, we_n:1, oe_n:0, drive:0, addr:int'(req_addr), data:int'(ref_rd(int'(req_addr))), is_rd:1, last:0};
          for (int k = 0; k < RDC; k++) begin
            t.last = (k == RDC - 1);
            q.push_back(t);
          end
        end
      end
      if (busy) idle_run = 0; else if (idle_run < 100) idle_run++;

      if (op_i >= NOPS && q.size() == 0 && !done_pend) tail++;
      cyc++;
      if (cyc > 3000) begin
        n_vec++; n_bad++;
        $display("FAIL R9 watchdog: got %0d cycles expected completion", cyc);
        break;
      end
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule